// File: doc/BRIEF.md
# Three-Pattern Strided Address Walker

This block produces element addresses for two source operands and one destination operand of a three-input elementwise operation. Each operand is described by a two-dimensional access pattern: a start address, two signed strides and two unsigned element counts. After a command is accepted, the block emits one matched address triple per accepted output handshake. All three patterns advance together, and the final triple is marked.

Each pattern walks its own shape. A stride of zero makes a pattern read the same element again, and this is how broadcast is expressed. The walk only starts when the three patterns hold the same number of elements, no count is zero and the lane count is legal. Otherwise the command is refused and a one-cycle error pulse is raised. The block moves no data and performs no arithmetic on data.

Top module: `tri_stride_walker`

## Requirements
- R1: After reset, cmd_ready is 1, out_valid is 0 and cfg_err is 0.
- R2: When a legal command is accepted (cmd_valid and cmd_ready at a rising edge), the next cycle has out_valid at 1 and the three start addresses on the outputs. cmd_ready stays 0 until the walk ends.
- R3: For element k of a pattern with inner count n0, the output address is start + (k mod n0)*stride0 + (k div n0)*stride1, modulo 2^ADDR_W. Strides are two's-complement 16-bit values. Dimension 0 is the inner loop.
- R4: A stride of zero repeats the same address along its dimension, which gives broadcast.
- R5: While out_valid is 1 and out_ready is 0, the next cycle shows the same triple and the same last flag.
- R6: out_last is 1 on the final triple (element count0*count1-1) and on no other triple.
- R7: The cycle after the handshake of the final triple, out_valid is 0 and cmd_ready is 1.
- R8: If the product of src_a's counts differs from that of src_b or of dst, the command is refused. cfg_err is 1 for exactly the next cycle, out_valid stays 0 and cmd_ready stays 1.
- R9: A command with any count equal to zero is refused in the same way as R8.
- R10: A lane_count of 0 or above 128 is refused in the same way as R8. The values 1 and 128 are accepted.
- R11: Patterns with different shapes but equal totals each walk their own shape during the same run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Walker idle, command may be taken |
| lane_count | input | 8 | Active lane count, legal 1..128 |
| src_a_base | input | ADDR_W | Source A start address |
| src_a_stride0 | input | 16 | Source A inner stride, signed |
| src_a_stride1 | input | 16 | Source A outer stride, signed |
| src_a_count0 | input | 16 | Source A inner count |
| src_a_count1 | input | 16 | Source A outer count |
| src_b_base | input | ADDR_W | Source B start address |
| src_b_stride0 | input | 16 | Source B inner stride, signed |
| src_b_stride1 | input | 16 | Source B outer stride, signed |
| src_b_count0 | input | 16 | Source B inner count |
| src_b_count1 | input | 16 | Source B outer count |
| dst_base | input | ADDR_W | Destination start address |
| dst_stride0 | input | 16 | Destination inner stride, signed |
| dst_stride1 | input | 16 | Destination outer stride, signed |
| dst_count0 | input | 16 | Destination inner count |
| dst_count1 | input | 16 | Destination outer count |
| out_valid | output | 1 | Address triple present |
| out_ready | input | 1 | Consumer takes the triple |
| out_src_a_addr | output | ADDR_W | Source A element address |
| out_src_b_addr | output | ADDR_W | Source B element address |
| out_dst_addr | output | ADDR_W | Destination element address |
| out_last | output | 1 | Final triple of the walk |
| cfg_err | output | 1 | One-cycle pulse on a refused command |

## Verification
Two events can land in the same cycle: the error pulse of a refused command and the acceptance of the next command. cmd_ready stays high after a refusal, so a legal command can be taken while cfg_err is still showing. The bench holds cmd_valid high across a bad command followed directly by a good one. It requires the pulse in that cycle and then a walk that starts cleanly from the new start addresses. In a second overlap, the final triple is stalled: out_last must stay asserted through the stall, and the return of cmd_ready must follow the actual handshake.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int STEP_W = 16;
    localparam int CNT_W  = 16;
    localparam int TOT_W  = 2 * CNT_W;
    localparam int NPAT   = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

    typedef struct packed {
        walk_state_e        state;
        logic [TOT_W-1:0]   remain;
        logic               err;
    } walk_ctl_t;
endpackage

// File: rtl/tsw_shape_check.sv
module tsw_shape_check
    import tsw_pkg::*;
#(
    parameter int LANE_W   = 8,
    parameter int LANE_MAX = 128
) (
    input  logic [NPAT-1:0][CNT_W-1:0] count0_v,
    input  logic [NPAT-1:0][CNT_W-1:0] count1_v,
    input  logic [LANE_W-1:0]          lane_count,
    output logic                       shape_ok,
    output logic [TOT_W-1:0]           total
);
    logic [NPAT-1:0][TOT_W-1:0] prod_v;
    logic [NPAT-1:0]            nonzero_v;

    for (genvar g = 0; g < NPAT; g++) begin : g_prod
        assign prod_v[g]    = TOT_W'(count0_v[g]) * TOT_W'(count1_v[g]);
        assign nonzero_v[g] = (count0_v[g] != '0) && (count1_v[g] != '0);
    end

    logic lanes_ok;
    logic prods_equal;

    always_comb begin
        lanes_ok    = (lane_count != '0) && (lane_count <= LANE_W'(LANE_MAX));
        prods_equal = 1'b1;
        for (int g = 1; g < NPAT; g++) begin
            if (prod_v[g] != prod_v[0]) prods_equal = 1'b0;
        end
        shape_ok = lanes_ok && prods_equal && (&nonzero_v);
        total    = prod_v[0];
    end
endmodule

// File: rtl/tsw_pattern_gen.sv
module tsw_pattern_gen
    import tsw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] base,
    input  logic [STEP_W-1:0] stride0,
    input  logic [STEP_W-1:0] stride1,
    input  logic [CNT_W-1:0]  count0,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] inc0;
        logic [ADDR_W-1:0] inc1;
        logic [CNT_W-1:0]  idx0;
        logic [CNT_W-1:0]  lim0;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (load) begin
            pg_d.addr = base;
            pg_d.row  = base;
            pg_d.inc0 = {{(ADDR_W-STEP_W){stride0[STEP_W-1]}}, stride0};
            pg_d.inc1 = {{(ADDR_W-STEP_W){stride1[STEP_W-1]}}, stride1};
            pg_d.idx0 = '0;
            pg_d.lim0 = count0 - 1'b1;
        end else if (adv) begin
            if (pg_q.idx0 == pg_q.lim0) begin
                pg_d.idx0 = '0;
                pg_d.row  = pg_q.row + pg_q.inc1;
                pg_d.addr = pg_q.row + pg_q.inc1;
            end else begin
                pg_d.idx0 = pg_q.idx0 + 1'b1;
                pg_d.addr = pg_q.addr + pg_q.inc0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign addr = pg_q.addr;

    a_r2_load_base: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(base)));

    a_r4_zero_stride_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (pg_q.idx0 != pg_q.lim0) && (pg_q.inc0 == '0)) |=> $stable(addr));
endmodule

// File: rtl/tri_stride_walker.sv
module tri_stride_walker
    import tsw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LANE_W   = 8,
    parameter int LANE_MAX = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [LANE_W-1:0] lane_count,
    input  logic [ADDR_W-1:0] src_a_base,
    input  logic [STEP_W-1:0] src_a_stride0,
    input  logic [STEP_W-1:0] src_a_stride1,
    input  logic [CNT_W-1:0]  src_a_count0,
    input  logic [CNT_W-1:0]  src_a_count1,
    input  logic [ADDR_W-1:0] src_b_base,
    input  logic [STEP_W-1:0] src_b_stride0,
    input  logic [STEP_W-1:0] src_b_stride1,
    input  logic [CNT_W-1:0]  src_b_count0,
    input  logic [CNT_W-1:0]  src_b_count1,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [STEP_W-1:0] dst_stride0,
    input  logic [STEP_W-1:0] dst_stride1,
    input  logic [CNT_W-1:0]  dst_count0,
    input  logic [CNT_W-1:0]  dst_count1,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_src_a_addr,
    output logic [ADDR_W-1:0] out_src_b_addr,
    output logic [ADDR_W-1:0] out_dst_addr,
    output logic              out_last,
    output logic              cfg_err
);
    logic [NPAT-1:0][ADDR_W-1:0] base_v;
    logic [NPAT-1:0][STEP_W-1:0] stride0_v;
    logic [NPAT-1:0][STEP_W-1:0] stride1_v;
    logic [NPAT-1:0][CNT_W-1:0]  count0_v;
    logic [NPAT-1:0][CNT_W-1:0]  count1_v;
    logic [NPAT-1:0][ADDR_W-1:0] addr_v;

    assign base_v    = {dst_base,    src_b_base,    src_a_base};
    assign stride0_v = {dst_stride0, src_b_stride0, src_a_stride0};
    assign stride1_v = {dst_stride1, src_b_stride1, src_a_stride1};
    assign count0_v  = {dst_count0,  src_b_count0,  src_a_count0};
    assign count1_v  = {dst_count1,  src_b_count1,  src_a_count1};

    logic             shape_ok;
    logic [TOT_W-1:0] total;

    tsw_shape_check #(
        .LANE_W   (LANE_W),
        .LANE_MAX (LANE_MAX)
    ) u_check (
        .count0_v   (count0_v),
        .count1_v   (count1_v),
        .lane_count (lane_count),
        .shape_ok   (shape_ok),
        .total      (total)
    );

    walk_ctl_t ctl_d, ctl_q;
    logic      accept;
    logic      fire;
    logic      start;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        accept    = cmd_valid && (ctl_q.state == ST_IDLE);
        fire      = (ctl_q.state == ST_WALK) && out_ready;
        start     = accept && shape_ok;
        if (accept) begin
            if (shape_ok) begin
                ctl_d.state  = ST_WALK;
                ctl_d.remain = total - 1'b1;
            end else begin
                ctl_d.err = 1'b1;
            end
        end else if (fire) begin
            if (ctl_q.remain == '0) ctl_d.state  = ST_IDLE;
            else                    ctl_d.remain = ctl_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, remain: '0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        tsw_pattern_gen #(
            .ADDR_W (ADDR_W)
        ) u_pat (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (start),
            .adv     (fire),
            .base    (base_v[g]),
            .stride0 (stride0_v[g]),
            .stride1 (stride1_v[g]),
            .count0  (count0_v[g]),
            .addr    (addr_v[g])
        );
    end

    assign cmd_ready      = (ctl_q.state == ST_IDLE);
    assign out_valid      = (ctl_q.state == ST_WALK);
    assign out_last       = out_valid && (ctl_q.remain == '0);
    assign cfg_err        = ctl_q.err;
    assign out_src_a_addr = addr_v[0];
    assign out_src_b_addr = addr_v[1];
    assign out_dst_addr   = addr_v[2];

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_src_a_addr)
            && $stable(out_src_b_addr) && $stable(out_dst_addr) && $stable(out_last)));

    a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (cmd_ready && !out_valid));

    a_r6_walk_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    a_r8_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (cmd_ready && !out_valid));
endmodule

// File: tb/sim_tri_stride_walker.sv
`timescale 1ns/100ps
module sim_tri_stride_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  lane_count = 8'd1;
    logic [31:0] base_p [3];
    logic [15:0] st0_p [3];
    logic [15:0] st1_p [3];
    logic [15:0] n0_p [3];
    logic [15:0] n1_p [3];
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] a_addr, b_addr, d_addr;
    logic        out_last;
    logic        cfg_err;

    int base_c [3];
    int st0_c [3];
    int st1_c [3];
    int n0_c [3];
    int n1_c [3];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tri_stride_walker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .lane_count(lane_count),
        .src_a_base(base_p[0]), .src_a_stride0(st0_p[0]), .src_a_stride1(st1_p[0]),
        .src_a_count0(n0_p[0]), .src_a_count1(n1_p[0]),
        .src_b_base(base_p[1]), .src_b_stride0(st0_p[1]), .src_b_stride1(st1_p[1]),
        .src_b_count0(n0_p[1]), .src_b_count1(n1_p[1]),
        .dst_base(base_p[2]), .dst_stride0(st0_p[2]), .dst_stride1(st1_p[2]),
        .dst_count0(n0_p[2]), .dst_count1(n1_p[2]),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_src_a_addr(a_addr), .out_src_b_addr(b_addr), .out_dst_addr(d_addr),
        .out_last(out_last), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pat(input int g, input int b, input int s0, input int s1, input int c0, input int c1);
        base_c[g] = b; st0_c[g] = s0; st1_c[g] = s1; n0_c[g] = c0; n1_c[g] = c1;
    endtask

    task automatic drive_cfg();
        for (int g = 0; g < 3; g++) begin
            base_p[g] = base_c[g];
            st0_p[g]  = st0_c[g][15:0];
            st1_p[g]  = st1_c[g][15:0];
            n0_p[g]   = n0_c[g][15:0];
            n1_p[g]   = n1_c[g][15:0];
        end
    endtask

    function automatic logic [31:0] addr_of(input int g, input int k);
        int i0, i1;
        i0 = k % n0_c[g];
        i1 = k / n0_c[g];
        return base_c[g] + i0 * st0_c[g] + i1 * st1_c[g];
    endfunction

    // Called at the negedge right after the accepting edge.
    task automatic compare_walk(input int mode, input string areq);
        int  total;
        int  k;
        int  cyc;
        bit  stalled;
        logic [31:0] got [3];
        total   = n0_c[0] * n1_c[0];
        k       = 0;
        cyc     = 0;
        stalled = 1'b0;
        while (k < total && cyc < 2000) begin
            bit rdy;
            got[0] = a_addr; got[1] = b_addr; got[2] = d_addr;
            chk(out_valid == 1'b1, "R2 out_valid during walk", 32'(out_valid), 32'd1);
            chk(cmd_ready == 1'b0, "R2 cmd_ready low during walk", 32'(cmd_ready), 32'd0);
            for (int g = 0; g < 3; g++)
                chk(got[g] == addr_of(g, k), stalled ? "R5 held triple" : areq, got[g], addr_of(g, k));
            chk(out_last == (k == total - 1), "R6 last flag", 32'(out_last), 32'(k == total - 1));
            case (mode)
                0: rdy = 1'b1;
                1: rdy = (cyc % 3) != 2;
                default: rdy = (cyc % 2) == 1;
            endcase
            out_ready = rdy;
            stalled = !rdy;
            @(negedge clk);
            if (rdy) k++;
            cyc++;
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R7 out_valid low after last", 32'(out_valid), 32'd0);
        chk(cmd_ready == 1'b1, "R7 cmd_ready back after last", 32'(cmd_ready), 32'd1);
    endtask

    task automatic issue();
        @(negedge clk);
        drive_cfg();
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic refuse(input string req);
        issue();
        chk(cfg_err == 1'b1, req, 32'(cfg_err), 32'd1);
        chk(out_valid == 1'b0, req, 32'(out_valid), 32'd0);
        chk(cmd_ready == 1'b1, req, 32'(cmd_ready), 32'd1);
        @(negedge clk);
        chk(cfg_err == 1'b0, req, 32'(cfg_err), 32'd0);
        chk(out_valid == 1'b0, req, 32'(out_valid), 32'd0);
    endtask

    initial begin
        for (int g = 0; g < 3; g++) set_pat(g, 0, 0, 0, 1, 1);
        drive_cfg();
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 reset cmd_ready", 32'(cmd_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
        chk(cfg_err == 1'b0, "R1 reset cfg_err", 32'(cfg_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 idle after reset", 32'(cmd_ready), 32'd1);

        // R11: three shapes, equal totals, no stall
        lane_count = 8'd128;
        set_pat(0, 32'h1000, 4, 40, 2, 3);
        set_pat(1, 32'h2000, 1, -10, 3, 2);
        set_pat(2, 32'h3000, 8, 0, 6, 1);
        issue();
        compare_walk(0, "R11 own shapes");

        // R4: broadcast with zero strides, under stalls
        lane_count = 8'd1;
        set_pat(0, 32'h400, 0, 16, 3, 2);
        set_pat(1, 32'h800, 0, 0, 2, 3);
        set_pat(2, 32'hC00, 4, 64, 3, 2);
        issue();
        compare_walk(1, "R4 broadcast");

        // R3: negative strides wrap modulo 2^32
        lane_count = 8'd64;
        set_pat(0, 32'h10, -8, -100, 2, 2);
        set_pat(1, 32'hFFFF_FFF8, 4, 8, 4, 1);
        set_pat(2, 32'h0, -1, 0, 1, 4);
        issue();
        compare_walk(2, "R3 signed strides");

        // R6: single element walk, last on the first triple, stalled
        set_pat(0, 32'h55, 3, 3, 1, 1);
        set_pat(1, 32'h66, 3, 3, 1, 1);
        set_pat(2, 32'h77, 3, 3, 1, 1);
        issue();
        compare_walk(2, "R6 single element");

        // R8: product mismatch
        set_pat(0, 32'h100, 1, 4, 2, 2);
        set_pat(1, 32'h200, 1, 4, 2, 2);
        set_pat(2, 32'h300, 1, 4, 5, 1);
        refuse("R8 product mismatch");

        // R9: zero count
        set_pat(0, 32'h100, 1, 4, 0, 2);
        set_pat(1, 32'h200, 1, 4, 0, 2);
        set_pat(2, 32'h300, 1, 4, 0, 2);
        refuse("R9 zero count");

        // R10: lane count out of range
        set_pat(0, 32'h100, 1, 4, 2, 2);
        set_pat(1, 32'h200, 1, 4, 2, 2);
        set_pat(2, 32'h300, 1, 4, 2, 2);
        lane_count = 8'd0;
        refuse("R10 lane count zero");
        lane_count = 8'd129;
        refuse("R10 lane count 129");

        // R8 + R2: refusal pulse seen while the next good command is taken
        lane_count = 8'd200;
        @(negedge clk);
        drive_cfg();
        cmd_valid = 1'b1;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R8 pulse with cmd held", 32'(cfg_err), 32'd1);
        chk(cmd_ready == 1'b1, "R8 ready during pulse", 32'(cmd_ready), 32'd1);
        lane_count = 8'd7;
        set_pat(0, 32'hA000, 2, 20, 2, 2);
        set_pat(1, 32'hB000, -2, 0, 4, 1);
        set_pat(2, 32'hC000, 0, 1, 1, 4);
        drive_cfg();
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cfg_err == 1'b0, "R8 pulse one cycle", 32'(cfg_err), 32'd0);
        compare_walk(1, "R2 back-to-back start");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule